// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from a parameterised set of sources (56 by default) and turns them into two processor interrupt lines: a fast line and a standard line. Each source line passes through a two-flop synchronizer. A per-source polarity bit then sets which level counts as active. A per-source software request bit can force the request on whatever the line does.

Every source carries a 4-bit priority and a one-bit destination that sends it to the fast line or the standard line. Each destination has its own 4-bit threshold. A pending source qualifies for its destination only when its priority is strictly greater than that threshold, so priority 0 never raises anything. For each destination the block registers an interrupt flag and a vector: the index of the qualifying source with the highest priority, with the lower index winning a tie.

A small synchronous register port sets each source's fields and the two thresholds. It also reads back the conditioned request, the qualifying status and both vectors. Nested service works by raising a destination's threshold to the level being served, so only strictly higher levels can interrupt again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While rst_n is low and after it is released, irq_fast and irq_std are 0. Both vectors read the none code (all ones, 63 by default). Every source word and both thresholds read 0.
- R2: The conditioned request of source i is (synchronized line XOR polarity) OR software bit. Polarity is bit 0 of the source word, and 1 means active-low. The conditioned request reads back at bit 7 of the source word.
- R3: A software request (bit 1 of the source word) makes the source pending whatever level its line has.
- R4: A source whose priority (bits 5:2 of the source word) is 0 never qualifies, never asserts a line and never appears in a vector.
- R5: Bit 6 of the source word selects the destination: 0 sends the source to irq_fast and vec_fast, and 1 sends it to irq_std and vec_std.
- R6: A pending source qualifies only if its priority is strictly greater than its destination's threshold. The fast threshold is at address 0x40 and the standard threshold at 0x41, in bits 3:0.
- R7: Each vector holds the index of the qualifying source with the highest priority for that destination. On equal priority the lowest index wins.
- R8: When no source qualifies for a destination, its line is 0 and its vector is all ones (the none code).
- R9: Outputs are registered. A register write shows on the outputs after one more clock edge. A change on a source line shows after three edges: two synchronizer edges and the output register.
- R10: Bit 8 of the source word reads 1 exactly when the source currently qualifies for its destination.
- R11: Source i is written and read at address i. Reads return the written fields. Addresses 0x42 and 0x43 read vec_fast and vec_std. Writes to those two addresses and to unused addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Asynchronous level request lines |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register address for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| irq_fast | output | 1 | Fast interrupt line |
| irq_std | output | 1 | Standard interrupt line |
| vec_fast | output | VEC_W | Winning source index for the fast line, all ones when idle |
| vec_std | output | VEC_W | Winning source index for the standard line, all ones when idle |

## Verification
The bench targets these cases:
- Equal priorities on one destination. A picker that lets the last index win would report source 30 instead of 12.
- A priority equal to the threshold. A comparison that is not strict would leave irq_fast raised.
- Priority 0 on a pending source. A priority-0 winner would pull vec_fast off index 55.
- The last index, 55, as the winner. An off-by-one scan would miss it.
- Exact latency: three edges from a line change and one from a write. An extra or missing synchronizer stage shifts the first cycle irq_fast rises.
- A long random phase mixing lines, polarity, software bits, destinations and thresholds against a behavioural model. This catches routing or polarity inversions.

// File: rtl/prio_irq_pkg.sv
// Shared constants and types of the priority interrupt controller.
// Assumes at most 64 sources so the source words fit below 0x40.
package prio_irq_pkg;
    localparam int PRIO_W = 4;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] ADDR_THR_FAST = 7'h40;
    localparam logic [ADDR_W-1:0] ADDR_THR_STD  = 7'h41;
    localparam logic [ADDR_W-1:0] ADDR_VEC_FAST = 7'h42;
    localparam logic [ADDR_W-1:0] ADDR_VEC_STD  = 7'h43;

    // Destination select encoding of a source word
    typedef enum logic {
        TGT_FAST = 1'b0,
        TGT_STD  = 1'b1
    } tgt_e;
endpackage

// File: rtl/prio_irq_sync.sv
// Two-flop synchronizer for a bus of independent level lines.
// Assumes each bit is a slow level; no bus coherence is implied.
module prio_irq_sync #(
    parameter int W = 56
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    // Shift the raw lines through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/prio_irq_regs.sv
// Configuration storage and request conditioning.
// Holds polarity, software request, priority and destination per source,
// plus the two thresholds; writes land on the clock edge that sees cfg_we.
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 56
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    input  logic [NUM_SRC-1:0]   line_sync,
    output logic [NUM_SRC-1:0]   pol_q,
    output logic [NUM_SRC-1:0]   sw_q,
    output logic [NUM_SRC-1:0]   tgt_q,
    output logic [PRIO_W-1:0]    pri_q [NUM_SRC],
    output logic [PRIO_W-1:0]    thr_fast_q,
    output logic [PRIO_W-1:0]    thr_std_q,
    output logic [NUM_SRC-1:0]   pend
);
    // Register writes for source words and thresholds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q      <= '0;
            sw_q       <= '0;
            tgt_q      <= '0;
            thr_fast_q <= '0;
            thr_std_q  <= '0;
            for (int i = 0; i < NUM_SRC; i++) pri_q[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (addr == ADDR_W'(i)) begin
                    pol_q[i] <= wdata[0];
                    sw_q[i]  <= wdata[1];
                    pri_q[i] <= wdata[2 +: PRIO_W];
                    tgt_q[i] <= wdata[6];
                end
            end
            if (addr == ADDR_THR_FAST) thr_fast_q <= wdata[PRIO_W-1:0];
            if (addr == ADDR_THR_STD)  thr_std_q  <= wdata[PRIO_W-1:0];
        end
    end

    // Apply polarity, then merge the software request
    always_comb begin
        pend = (line_sync ^ pol_q) | sw_q;
    end
endmodule

// File: rtl/prio_irq_pick.sv
// Winner selection for one destination.
// Qualifies pending sources routed here whose priority exceeds the
// threshold, picks the highest priority (lowest index on ties) and
// registers the line and the vector. Vector is all ones when idle.
module prio_irq_pick
    import prio_irq_pkg::*;
#(
    parameter int   NUM_SRC = 56,
    parameter int   VEC_W   = 6,
    parameter logic TGT_SEL = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  pend,
    input  logic [NUM_SRC-1:0]  tgt,
    input  logic [PRIO_W-1:0]   pri [NUM_SRC],
    input  logic [PRIO_W-1:0]   thr,
    output logic [NUM_SRC-1:0]  qual,
    output logic                irq,
    output logic [VEC_W-1:0]    vec
);
    logic [PRIO_W-1:0] best_pri;
    logic [VEC_W-1:0]  best_idx;
    logic              found;

    // Mark sources that are pending, routed here and above threshold
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            qual[i] = pend[i] && (tgt[i] == TGT_SEL) && (pri[i] > thr);
        end
    end

    // Scan downward so an equal priority at a lower index replaces the holder
    always_comb begin
        best_pri = '0;
        best_idx = '1;
        found    = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (qual[i] && (!found || pri[i] >= best_pri)) begin
                found    = 1'b1;
                best_pri = pri[i];
                best_idx = VEC_W'(i);
            end
        end
    end

    // Register the interrupt line and the vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            vec <= '1;
        end else begin
            irq <= found;
            vec <= best_idx;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the priority interrupt controller.
// Synchronizes the lines, conditions them, picks a winner per destination
// and serves the register read port combinationally from cfg_addr.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter  int NUM_SRC = 56,
    localparam int VEC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_in,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    output logic                 irq_fast,
    output logic                 irq_std,
    output logic [VEC_W-1:0]     vec_fast,
    output logic [VEC_W-1:0]     vec_std
);
    logic [NUM_SRC-1:0] line_sync;
    logic [NUM_SRC-1:0] pol_q, sw_q, tgt_q, pend;
    logic [PRIO_W-1:0]  pri_q [NUM_SRC];
    logic [PRIO_W-1:0]  thr_fast_q, thr_std_q;
    logic [NUM_SRC-1:0] qual_t [2];
    logic               irq_t  [2];
    logic [VEC_W-1:0]   vec_t  [2];

    prio_irq_sync #(.W(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (irq_in),
        .q_sync  (line_sync)
    );

    prio_irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .line_sync  (line_sync),
        .pol_q      (pol_q),
        .sw_q       (sw_q),
        .tgt_q      (tgt_q),
        .pri_q      (pri_q),
        .thr_fast_q (thr_fast_q),
        .thr_std_q  (thr_std_q),
        .pend       (pend)
    );

    for (genvar t = 0; t < 2; t++) begin : g_tgt
        prio_irq_pick #(
            .NUM_SRC (NUM_SRC),
            .VEC_W   (VEC_W),
            .TGT_SEL (1'(t))
        ) u_pick (
            .clk   (clk),
            .rst_n (rst_n),
            .pend  (pend),
            .tgt   (tgt_q),
            .pri   (pri_q),
            .thr   ((t == 0) ? thr_fast_q : thr_std_q),
            .qual  (qual_t[t]),
            .irq   (irq_t[t]),
            .vec   (vec_t[t])
        );
    end

    assign irq_fast = irq_t[0];
    assign irq_std  = irq_t[1];
    assign vec_fast = vec_t[0];
    assign vec_std  = vec_t[1];

    // Decode the read address into source words, thresholds or vectors
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cfg_addr == ADDR_W'(i)) begin
                cfg_rdata[0]          = pol_q[i];
                cfg_rdata[1]          = sw_q[i];
                cfg_rdata[2 +: PRIO_W] = pri_q[i];
                cfg_rdata[6]          = tgt_q[i];
                cfg_rdata[7]          = pend[i];
                cfg_rdata[8]          = qual_t[0][i] | qual_t[1][i];
            end
        end
        if (cfg_addr == ADDR_THR_FAST) cfg_rdata[PRIO_W-1:0] = thr_fast_q;
        if (cfg_addr == ADDR_THR_STD)  cfg_rdata[PRIO_W-1:0] = thr_std_q;
        if (cfg_addr == ADDR_VEC_FAST) cfg_rdata[VEC_W-1:0]  = vec_t[0];
        if (cfg_addr == ADDR_VEC_STD)  cfg_rdata[VEC_W-1:0]  = vec_t[1];
    end
endmodule

// File: rtl/prio_irq_chk.sv
// Property checker for the priority interrupt controller.
// Keeps a one-cycle copy of the configuration so that each registered
// output can be related to the settings it was computed from.
module prio_irq_chk
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 56,
    parameter int VEC_W   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq_fast,
    input logic                irq_std,
    input logic [VEC_W-1:0]    vec_fast,
    input logic [VEC_W-1:0]    vec_std,
    input logic [PRIO_W-1:0]   pri_q [NUM_SRC],
    input logic [NUM_SRC-1:0]  tgt_q,
    input logic [PRIO_W-1:0]   thr_fast_q,
    input logic [PRIO_W-1:0]   thr_std_q
);
    logic [PRIO_W-1:0]  prev_pri [NUM_SRC];
    logic [NUM_SRC-1:0] prev_tgt;
    logic [PRIO_W-1:0]  prev_thr_fast, prev_thr_std;

    // Capture the settings the output registers sampled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tgt      <= '0;
            prev_thr_fast <= '0;
            prev_thr_std  <= '0;
            for (int i = 0; i < NUM_SRC; i++) prev_pri[i] <= '0;
        end else begin
            prev_pri      <= pri_q;
            prev_tgt      <= tgt_q;
            prev_thr_fast <= thr_fast_q;
            prev_thr_std  <= thr_std_q;
        end
    end

    // R8
    fast_idle_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_fast |-> vec_fast == {VEC_W{1'b1}});
    // R8
    std_idle_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_std |-> vec_std == {VEC_W{1'b1}});
    // R7
    fast_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> int'(vec_fast) < NUM_SRC);
    // R7
    std_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_std |-> int'(vec_std) < NUM_SRC);
    // R6
    fast_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> prev_pri[vec_fast] > prev_thr_fast);
    // R6
    std_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_std |-> prev_pri[vec_std] > prev_thr_std);
    // R5
    fast_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> prev_tgt[vec_fast] == TGT_FAST);
    // R5
    std_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_std |-> prev_tgt[vec_std] == TGT_STD);
    // R4
    fast_nonzero_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> prev_pri[vec_fast] != '0);
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_fast   (irq_fast),
    .irq_std    (irq_std),
    .vec_fast   (vec_fast),
    .vec_std    (vec_std),
    .pri_q      (pri_q),
    .tgt_q      (tgt_q),
    .thr_fast_q (thr_fast_q),
    .thr_std_q  (thr_std_q)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
    import prio_irq_pkg::*;

    localparam int N    = 56;
    localparam int VW   = $clog2(N + 1);
    localparam int NONE = (1 << VW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      irq_in = '0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              irq_fast, irq_std;
    logic [VW-1:0]     vec_fast, vec_std;

    always #4 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(N)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .irq_fast  (irq_fast),
        .irq_std   (irq_std),
        .vec_fast  (vec_fast),
        .vec_std   (vec_std)
    );

    // ---------------- behavioural reference model ----------------
    bit           m_pol [N];
    bit           m_sw  [N];
    int           m_tgt [N];
    int           m_pri [N];
    int           m_thr [2];
    bit [N-1:0]   m_s1, m_s2;
    bit           m_irq [2];
    int           m_vec [2];

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    function automatic bit m_pend(int i);
        return (m_s2[i] ^ m_pol[i]) | m_sw[i];
    endfunction

    function automatic bit m_qual(int i, int t);
        return m_pend(i) && (m_tgt[i] == t) && (m_pri[i] > m_thr[t]);
    endfunction

    function automatic int m_win(int t);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (m_qual(i, t) && (best < 0 || m_pri[i] > m_pri[best])) best = i;
        return best;
    endfunction

    function automatic logic [31:0] m_rdata(int a);
        if (a < N)
            return 32'(m_pol[a]) | (32'(m_sw[a]) << 1) | (32'(m_pri[a]) << 2) |
                   (32'(m_tgt[a]) << 6) | (32'(m_pend(a)) << 7) |
                   (32'(m_qual(a, 0) | m_qual(a, 1)) << 8);
        if (a == 'h40) return 32'(m_thr[0]);
        if (a == 'h41) return 32'(m_thr[1]);
        if (a == 'h42) return 32'(m_vec[0]);
        if (a == 'h43) return 32'(m_vec[1]);
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        int w;
        int a;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_pol[i] = 0; m_sw[i] = 0; m_tgt[i] = 0; m_pri[i] = 0;
            end
            m_thr[0] = 0; m_thr[1] = 0;
            m_s1 = '0; m_s2 = '0;
            m_irq[0] = 0; m_irq[1] = 0;
            m_vec[0] = NONE; m_vec[1] = NONE;
        end else begin
            for (int t = 0; t < 2; t++) begin
                w = m_win(t);
                m_irq[t] = (w >= 0);
                m_vec[t] = (w >= 0) ? w : NONE;
            end
            if (cfg_we) begin
                a = int'(cfg_addr);
                if (a < N) begin
                    m_pol[a] = cfg_wdata[0];
                    m_sw[a]  = cfg_wdata[1];
                    m_pri[a] = int'(cfg_wdata[5:2]);
                    m_tgt[a] = int'(cfg_wdata[6]);
                end else if (a == 'h40) m_thr[0] = int'(cfg_wdata[3:0]);
                else if (a == 'h41) m_thr[1] = int'(cfg_wdata[3:0]);
            end
            m_s2 = m_s1;
            m_s1 = irq_in;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare every cycle against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            check("R9 irq_fast vs model", 32'(irq_fast), 32'(m_irq[0]));
            check("R9 irq_std vs model", 32'(irq_std), 32'(m_irq[1]));
            check("R7 vec_fast vs model", 32'(vec_fast), 32'(m_vec[0]));
            check("R7 vec_std vs model", 32'(vec_std), 32'(m_vec[1]));
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(a); cfg_wdata = 32'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic src(int i, int pol, int sw, int pri, int tgt);
        wr(i, (tgt << 6) | (pri << 2) | (sw << 1) | pol);
    endtask

    task automatic rd(int a, int exp, string tag);
        @(negedge clk);
        cfg_addr = ADDR_W'(a);
        #1;
        check(tag, cfg_rdata, 32'(exp));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R1 reset state
        check("R1 irq_fast after reset", 32'(irq_fast), 0);
        check("R1 irq_std after reset", 32'(irq_std), 0);
        rd(0, 0, "R1 source word 0");
        rd('h41, 0, "R1 std threshold");
        rd('h42, NONE, "R8 vec_fast none at reset");
        rd('h43, NONE, "R8 vec_std none at reset");

        // R9 line latency: three edges
        src(5, 0, 0, 3, 0);
        @(negedge clk); irq_in[5] = 1'b1;
        @(negedge clk); check("R9 line +1 edge", 32'(irq_fast), 0);
        @(negedge clk); check("R9 line +2 edges", 32'(irq_fast), 0);
        @(negedge clk); check("R9 line +3 edges", 32'(irq_fast), 1);
        check("R7 single winner", 32'(vec_fast), 5);
        rd(5, 12 + 128 + 256, "R2 R10 pending and qualifying word");

        // R2 active-low polarity with line low; R4 priority 0 stays masked
        src(7, 1, 0, 0, 0);
        rd(7, 1 + 128, "R2 active-low pending, R4 not qualifying");
        check("R4 pri0 source not chosen", 32'(vec_fast), 5);

        // R3 software request, R5 routing to standard line
        src(10, 0, 1, 6, 1);
        check("R9 write latency before edge", 32'(irq_std), 0);
        @(negedge clk);
        check("R3 software request raises std", 32'(irq_std), 1);
        check("R5 std vector", 32'(vec_std), 10);
        check("R5 fast vector unaffected", 32'(vec_fast), 5);

        // R6 threshold strictness
        wr('h40, 3);
        @(negedge clk);
        check("R6 priority equal to threshold masked", 32'(irq_fast), 0);
        src(5, 0, 0, 4, 0);
        @(negedge clk);
        check("R6 priority above threshold", 32'(irq_fast), 1);
        check("R6 vector above threshold", 32'(vec_fast), 5);

        // R7 ties and ordering
        src(30, 0, 1, 9, 0);
        src(12, 0, 1, 9, 0);
        @(negedge clk);
        check("R7 tie lowest index", 32'(vec_fast), 12);
        src(55, 0, 1, 10, 0);
        @(negedge clk);
        check("R7 highest priority last index", 32'(vec_fast), 55);
        src(0, 0, 1, 10, 0);
        @(negedge clk);
        check("R7 tie at index 0", 32'(vec_fast), 0);
        src(0, 0, 1, 0, 0);
        @(negedge clk);
        check("R4 pri0 drops out", 32'(vec_fast), 55);
        rd(0, 2 + 128, "R10 pending but not qualifying");

        // R11 readback and ignored writes
        rd('h40, 3, "R11 fast threshold readback");
        wr('h42, 0);
        rd('h42, 55, "R11 write to vector ignored");
        wr('h50, 32'hFFFF);
        rd('h50, 0, "R11 unused address reads 0");
        rd(55, 2 + (10 << 2) + 128 + 256, "R11 source 55 readback");

        // R6 nesting: raise std threshold to the level in service
        wr('h41, 6);
        @(negedge clk);
        check("R6 nesting masks equal level", 32'(irq_std), 0);
        check("R8 std vector none", 32'(vec_std), NONE);

        // Random phase against the model
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            irq_in = N'({$urandom(), $urandom()});
            if ($urandom() % 3 == 0) begin
                cfg_we = 1'b1;
                cfg_wdata = $urandom();
            end else begin
                cfg_we = 1'b0;
            end
            cfg_addr = ADDR_W'($urandom() % 72);
            #1;
            check("R11 random readback", cfg_rdata, m_rdata(int'(cfg_addr)));
        end
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        cmp_en = 1'b0;
        summary();
        $finish;
    end
endmodule